// File: doc/BRIEF.md
# Real-Time Clock Serial Shift Port

This block is the slave side of the serial port of a real-time clock. A host drives four lines: a chip enable, a direction select, a serial clock and a data line. While chip enable is high, the direction select chooses the mode. When it is low the port sends a 52-bit packed BCD snapshot of the time and calendar counters. When it is high the port takes in 52 bits and hands them to the counters as a single parallel load. The serial clock and chip enable are taken as already synchronised to the system clock. The port finds their edges by comparing each with its value one system clock earlier. The data line is split into an input, an output and an output enable.

Two status bits travel inside the frame. The first is a sticky supply-fail flag, set by the voltage detector. It is cleared only by a read that runs long enough, or by a committed write. The second is a test bit, which a write can set and which is cleared whenever chip enable is low. During a write the port also holds the counters still, so that a frame being written is not overtaken by a seconds carry.

Frame bit positions, counted from the first bit on the line: the seconds occupy bits 0 to 6 and the supply-fail flag is bit 7. The minutes are bits 8 to 14, the hours bits 16 to 21 and the weekday bits 24 to 26. The day of the month is bits 28 to 33, the month bits 36 to 40 and the test bit is bit 43. The year is bits 44 to 51. All fields are BCD and the spare positions carry any value.

Top module: `rtc_serial_port`

## Requirements
- R1: After reset, sdo_oe, load_stb and cnt_hold are 0, test_mode is 0 and fail_flag is 1.
- R2: Read mode is chip_en high with wr_dir 0. The first rising sclk edge captures time_word, with frame bit 7 replaced by fail_flag and bit 43 by test_mode. After that edge sdo shows frame bit 0, and each later rising edge advances one bit, LSB first. sdo_oe is 0 before the first edge and 1 from that edge while chip_en stays high.
- R3: A read ends early when chip_en falls. sdo_oe then drops, and the next read starts again from frame bit 0.
- R4: A read whose 48th rising sclk edge occurs clears fail_flag. A read of 47 edges or fewer leaves it set.
- R5: A high supply_low sets fail_flag. This takes priority over every clearing or loading of the flag.
- R6: Write mode is chip_en high with wr_dir 1. Bits are taken on rising sclk edges, LSB first. On the 52nd edge load_stb pulses for exactly one system cycle, and load_word bit i holds the i-th bit received, counting from 0.
- R7: A committed write loads fail_flag from frame bit 7 and test_mode from frame bit 43.
- R8: If chip_en falls before the 52nd write bit, there is no load_stb and fail_flag is unchanged.
- R9: Write bits after the 52nd produce no further strobe and leave load_word unchanged.
- R10: cnt_hold rises on the first falling sclk edge in write mode. It stays high after chip_en falls and clears on the next rising edge of chip_en.
- R11: While chip_en is low, sclk and sdi are ignored, sdo_oe is 0 and test_mode is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable, synchronised |
| wr_dir | input | 1 | Direction: 1 write, 0 read |
| sclk | input | 1 | Serial clock, synchronised |
| sdi | input | 1 | Serial data in |
| supply_low | input | 1 | Low-supply report from the detector |
| time_word | input | 52 | Packed counter values for a read |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Enable for the data line driver |
| load_stb | output | 1 | One-cycle counter load strobe |
| load_word | output | 52 | Received frame for the counter load |
| cnt_hold | output | 1 | Holds the counters during a write |
| fail_flag | output | 1 | Sticky supply-fail flag |
| test_mode | output | 1 | Test bit |

## Verification
The bench probes the supply-fail clear threshold with reads of 47 and 48 bits. A design that is off by one would clear the flag one bit too early or too late. It aborts a write after 30 bits, where a design that commits partial frames would pulse load_stb or change the flag. It overruns a write by four bits, where a design without a saturating count would strobe again or shift the stored word. It also checks that cnt_hold outlives the write's chip enable, that sclk pulses with chip enable low leave a following read aligned at bit 0, and that a restarted read begins at bit 0 rather than where the previous one stopped.

// File: rtl/rtc_sp_pkg.sv
package rtc_sp_pkg;
  localparam int SP_FRAME_W  = 52;
  localparam int SP_FLAG_BIT = 7;
  localparam int SP_TEST_BIT = 43;
  localparam int SP_CLEAR_AT = 48;

  typedef enum logic [1:0] {
    SP_IDLE  = 2'd0,
    SP_READ  = 2'd1,
    SP_WRITE = 2'd2
  } sp_mode_e;
endpackage

// File: rtl/rtc_sp_prev.sv
module rtc_sp_prev #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= 1'b0;
      else        r <= d[i];
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/rtc_sp_seq.sv
module rtc_sp_seq
  import rtc_sp_pkg::*;
#(
  parameter int FRAME_W  = SP_FRAME_W,
  parameter int CLEAR_AT = SP_CLEAR_AT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic wr_dir,
  input  logic sclk,
  input  logic sclk_prev,
  input  logic ce_prev,
  output logic rd_load,
  output logic rd_shift,
  output logic wr_shift,
  output logic wr_last,
  output logic rd_clear,
  output logic rd_active,
  output logic cnt_hold
);
  localparam int CW = $clog2(FRAME_W + 2);
  localparam logic [CW-1:0] SAT   = CW'(FRAME_W + 1);
  localparam logic [CW-1:0] LAST  = CW'(FRAME_W - 1);
  localparam logic [CW-1:0] FULL  = CW'(FRAME_W);
  localparam logic [CW-1:0] CLR_C = CW'(CLEAR_AT - 1);

  sp_mode_e      mode;
  logic          s_rise, s_fall, ce_rise;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold_d, act_d;

  always_comb begin
    if (!chip_en)    mode = SP_IDLE;
    else if (wr_dir) mode = SP_WRITE;
    else             mode = SP_READ;
    s_rise  = chip_en & sclk & ~sclk_prev;
    s_fall  = chip_en & ~sclk & sclk_prev;
    ce_rise = chip_en & ~ce_prev;

    rd_load  = (mode == SP_READ)  && s_rise && (cnt_q == '0);
    rd_shift = (mode == SP_READ)  && s_rise && (cnt_q != '0) && (cnt_q < FULL);
    rd_clear = (mode == SP_READ)  && s_rise && (cnt_q == CLR_C);
    wr_shift = (mode == SP_WRITE) && s_rise && (cnt_q < FULL);
    wr_last  = (mode == SP_WRITE) && s_rise && (cnt_q == LAST);

    cnt_d = cnt_q;
    if (!chip_en)                 cnt_d = '0;
    else if (s_rise && cnt_q < SAT) cnt_d = cnt_q + 1'b1;

    hold_d = cnt_hold;
    if (ce_rise)                                hold_d = 1'b0;
    else if ((mode == SP_WRITE) && s_fall)      hold_d = 1'b1;

    act_d = rd_active;
    if (mode != SP_READ) act_d = 1'b0;
    else if (rd_load)    act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cnt_hold  <= 1'b0;
      rd_active <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      cnt_hold  <= hold_d;
      rd_active <= act_d;
    end
  end

  a_r11_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (cnt_q == '0));
  a_r10_hold_rise_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnt_hold) |-> $past(chip_en && wr_dir));
  a_r10_hold_ce_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !ce_prev) |=> !cnt_hold);
  a_r9_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == SAT) && chip_en |=> (cnt_q == SAT));
endmodule

// File: rtl/rtc_sp_shift.sv
module rtc_sp_shift #(
  parameter int FRAME_W = 52
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_load,
  input  logic               rd_shift,
  input  logic               wr_shift,
  input  logic               wr_last,
  input  logic [FRAME_W-1:0] snap,
  input  logic               sdi,
  output logic               sdo,
  output logic               load_stb,
  output logic [FRAME_W-1:0] load_word
);
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               stb_d;

  always_comb begin
    sh_d = sh_q;
    if (rd_load)       sh_d = snap;
    else if (rd_shift) sh_d = sh_q >> 1;
    else if (wr_shift) sh_d = {sdi, sh_q[FRAME_W-1:1]};
    stb_d = wr_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      load_stb <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      load_stb <= stb_d;
    end
  end

  assign sdo       = sh_q[0];
  assign load_word = sh_q;

  a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
  a_r9_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> $stable(load_word));
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import rtc_sp_pkg::*;
#(
  parameter int FRAME_W  = SP_FRAME_W,
  parameter int FLAG_BIT = SP_FLAG_BIT,
  parameter int TEST_BIT = SP_TEST_BIT,
  parameter int CLEAR_AT = SP_CLEAR_AT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chip_en,
  input  logic               wr_dir,
  input  logic               sclk,
  input  logic               sdi,
  input  logic               supply_low,
  input  logic [FRAME_W-1:0] time_word,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               load_stb,
  output logic [FRAME_W-1:0] load_word,
  output logic               cnt_hold,
  output logic               fail_flag,
  output logic               test_mode
);
  logic [1:0]         prev;
  logic               rd_load, rd_shift, wr_shift, wr_last, rd_clear, rd_active;
  logic [FRAME_W-1:0] snap;
  logic               flag_d, test_d;

  rtc_sp_prev #(.W(2)) i_prev (
    .clk(clk), .rst_n(rst_n), .d({chip_en, sclk}), .q(prev)
  );

  rtc_sp_seq #(.FRAME_W(FRAME_W), .CLEAR_AT(CLEAR_AT)) i_seq (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_dir(wr_dir),
    .sclk(sclk), .sclk_prev(prev[0]), .ce_prev(prev[1]),
    .rd_load(rd_load), .rd_shift(rd_shift), .wr_shift(wr_shift),
    .wr_last(wr_last), .rd_clear(rd_clear), .rd_active(rd_active),
    .cnt_hold(cnt_hold)
  );

  rtc_sp_shift #(.FRAME_W(FRAME_W)) i_shift (
    .clk(clk), .rst_n(rst_n), .rd_load(rd_load), .rd_shift(rd_shift),
    .wr_shift(wr_shift), .wr_last(wr_last), .snap(snap), .sdi(sdi),
    .sdo(sdo), .load_stb(load_stb), .load_word(load_word)
  );

  always_comb begin
    snap           = time_word;
    snap[FLAG_BIT] = fail_flag;
    snap[TEST_BIT] = test_mode;

    flag_d = fail_flag;
    if (supply_low)    flag_d = 1'b1;
    else if (load_stb) flag_d = load_word[FLAG_BIT];
    else if (rd_clear) flag_d = 1'b0;

    test_d = test_mode;
    if (!chip_en)      test_d = 1'b0;
    else if (load_stb) test_d = load_word[TEST_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_flag <= 1'b1;
      test_mode <= 1'b0;
    end else begin
      fail_flag <= flag_d;
      test_mode <= test_d;
    end
  end

  assign sdo_oe = rd_active & chip_en & ~wr_dir;

  a_r5_supply_sets: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> fail_flag);
  a_r11_test_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> !test_mode);
  a_r6_stb_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(chip_en && wr_dir));
  a_r4_flag_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail_flag) |-> $past(chip_en));
endmodule

// File: tb/test_rtc_serial_port.sv
module test_rtc_serial_port;
  localparam int FW = 52;

  logic          clk, rst_n, chip_en, wr_dir, sclk, sdi, supply_low;
  logic [FW-1:0] time_word;
  logic          sdo, sdo_oe, load_stb, cnt_hold, fail_flag, test_mode;
  logic [FW-1:0] load_word;

  int   n_checks, n_fail, n_stb;
  logic done;
  logic [FW-1:0] word_seen;

  rtc_serial_port i_rtc_serial_port (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .wr_dir(wr_dir),
    .sclk(sclk), .sdi(sdi), .supply_low(supply_low), .time_word(time_word),
    .sdo(sdo), .sdo_oe(sdo_oe), .load_stb(load_stb), .load_word(load_word),
    .cnt_hold(cnt_hold), .fail_flag(fail_flag), .test_mode(test_mode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one serial bit: raise sclk, sample after the capturing edge, then lower
  task automatic sbit(input logic d, output logic q);
    @(negedge clk);
    sdi  = d;
    sclk = 1'b1;
    @(negedge clk);
    q = sdo;
    if (load_stb) begin
      n_stb++;
      word_seen = load_word;
    end
    @(negedge clk);
    sclk = 1'b0;
    tick(2);
  endtask

  task automatic ce_start(input logic dir);
    @(negedge clk);
    wr_dir  = dir;
    chip_en = 1'b1;
    tick(2);
  endtask

  task automatic ce_stop();
    @(negedge clk);
    chip_en = 1'b0;
    tick(2);
  endtask

  task automatic do_write(input logic [FW-1:0] w, input int nbits);
    logic q;
    n_stb = 0;
    ce_start(1'b1);
    for (int i = 0; i < nbits; i++) begin
      sbit((i < FW) ? w[i] : ~w[i % FW], q);
      if (i == 0) check(cnt_hold == 1'b1, "R10 hold after first fall", cnt_hold, 1);
    end
    tick(2);
  endtask

  task automatic do_read(input int nbits, input logic flag_exp, input string req);
    logic [FW-1:0] exp_w;
    logic q;
    int bad;
    bad   = 0;
    exp_w = time_word;
    exp_w[7]  = flag_exp;
    exp_w[43] = 1'b0;
    ce_start(1'b0);
    check(sdo_oe == 1'b0, "R2 oe low before first edge", sdo_oe, 0);
    for (int i = 0; i < nbits; i++) begin
      sbit(1'b0, q);
      if (i < FW && q !== exp_w[i]) bad++;
    end
    check(bad == 0, req, bad, 0);
    check(sdo_oe == 1'b1, "R2 oe high during read", sdo_oe, 1);
    ce_stop();
    check(sdo_oe == 1'b0, "R3 oe low after chip enable falls", sdo_oe, 0);
  endtask

  task automatic t_reset();
    check(sdo_oe == 0 && load_stb == 0 && cnt_hold == 0, "R1 outputs idle",
          {sdo_oe, load_stb, cnt_hold}, 0);
    check(fail_flag == 1'b1, "R1 flag set at reset", fail_flag, 1);
    check(test_mode == 1'b0, "R1 test bit clear", test_mode, 0);
  endtask

  task automatic t_write_commit(input logic [FW-1:0] w);
    do_write(w, FW);
    check(n_stb == 1, "R6 single strobe", n_stb, 1);
    check(word_seen == w, "R6 load word", word_seen, w);
    check(fail_flag == w[7], "R7 flag from bit 7", fail_flag, w[7]);
    check(test_mode == w[43], "R7 test from bit 43", test_mode, w[43]);
    ce_stop();
    check(test_mode == 1'b0, "R11 test cleared with chip enable low", test_mode, 0);
    check(cnt_hold == 1'b1, "R10 hold outlives chip enable", cnt_hold, 1);
    ce_start(1'b0);
    check(cnt_hold == 1'b0, "R10 hold released on chip enable rise", cnt_hold, 0);
    ce_stop();
  endtask

  task automatic t_write_abort(input logic [FW-1:0] w);
    logic f0;
    f0 = fail_flag;
    do_write(w, 30);
    ce_stop();
    tick(2);
    check(n_stb == 0, "R8 no strobe on short write", n_stb, 0);
    check(fail_flag == f0, "R8 flag kept on short write", fail_flag, f0);
  endtask

  task automatic t_write_overrun(input logic [FW-1:0] w);
    do_write(w, FW + 4);
    check(n_stb == 1, "R9 one strobe despite extra bits", n_stb, 1);
    check(load_word == w, "R9 word unchanged by extra bits", load_word, w);
    ce_stop();
  endtask

  task automatic t_supply();
    @(negedge clk);
    supply_low = 1'b1;
    @(negedge clk);
    supply_low = 1'b0;
    tick(1);
    check(fail_flag == 1'b1, "R5 supply low sets flag", fail_flag, 1);
  endtask

  task automatic t_ce_low_ignore();
    logic q;
    for (int i = 0; i < 5; i++) sbit(1'b1, q);
    check(sdo_oe == 1'b0 && n_stb == 0, "R11 clocks ignored with chip enable low",
          sdo_oe, 0);
    check(cnt_hold == 1'b0, "R11 no hold from idle clocks", cnt_hold, 0);
  endtask

  initial begin
    logic [FW-1:0] w1, w2, w3;
    n_checks = 0; n_fail = 0; n_stb = 0; done = 1'b0;
    rst_n = 1'b0; chip_en = 1'b0; wr_dir = 1'b0; sclk = 1'b0; sdi = 1'b0;
    supply_low = 1'b0; time_word = 52'h9_1234_5678_9ABC;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();

    w1 = 52'h2_5311_2403_4559; w1[7] = 1'b1; w1[43] = 1'b1;
    t_write_commit(w1);

    time_word = 52'h9_8123_1406_2347;
    do_read(FW, 1'b1, "R2 full read frame");
    check(fail_flag == 1'b0, "R4 flag cleared by 52-bit read", fail_flag, 0);

    w3 = 52'h7_0612_0518_3320; w3[7] = 1'b1;
    t_write_abort(w3);

    t_supply();
    do_read(47, 1'b1, "R2 47-bit read frame");
    check(fail_flag == 1'b1, "R4 flag kept by 47-bit read", fail_flag, 1);
    do_read(48, 1'b1, "R2 48-bit read frame");
    check(fail_flag == 1'b0, "R4 flag cleared by 48-bit read", fail_flag, 0);

    time_word = 52'h0_5A6B_7C8D_9E0F;
    t_ce_low_ignore();
    do_read(28, 1'b0, "R3 early-ended read");
    do_read(10, 1'b0, "R3 restarted read from bit 0");
    do_read(FW + 4, 1'b0, "R2 overrun read frame");

    w2 = 52'h1_0401_2305_5937; w2[7] = 1'b0; w2[43] = 1'b0;
    t_write_overrun(w2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule